// File: doc/BRIEF.md
# Synchronous Burst SRAM with Registered Control

This block models a single-data-rate synchronous static memory whose controls are all sampled on the rising clock edge. Three chip selects, two address strobes, an advance input and a set of write qualifiers are decoded into core operations. The strobes come from two sources: one from a processor and one from a cache controller. The word is split into byte lanes. A global write stores every lane. A byte-write enable combined with per-lane selects stores chosen lanes only. A two-bit burst counter steps the low address bits in either linear or interleaved order, selected by a static strap input.

Read data is registered, so it appears during the cycle after the edge that sampled the address. It is driven onto the bus only while the asynchronous output enable is low. The bus is split into an input word, an output word and a drive qualifier, so that the pad ring can build the bidirectional pins. A sleep input freezes all control state and blocks writes, while keeping the stored words.

The default depth is kept small so the block elaborates quickly. Setting `ADDR_W` to 17 gives the full 128K-word organisation.

Top module: `burst_sram`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `dq_drive` is 0, and the memory counts as deselected.
- R2: A cycle starts when `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0 and a strobe is low at a clock edge. For a read, the word at the sampled address is on `dq_out` with `dq_drive`=1 after that edge, until the next edge, provided `out_en_n` is low.
- R3: `out_en_n` acts without a clock edge. Raising it clears `dq_drive` at once, and lowering it restores the drive of the held read word.
- R4: A cycle started by `proc_strobe_n` is a read in its first cycle, even if write inputs are asserted. `proc_strobe_n` is ignored entirely when `cs_a_n` is high.
- R5: A cycle started by `ctrl_strobe_n` with a write request writes at the sampled address in that same cycle, and without one it reads. A recognised strobe with any chip select inactive deselects the memory.
- R6: With `all_wr_n` low, a write stores all four lanes, whatever `byte_wr_en_n` and `lane_sel_n` are.
- R7: Otherwise, lane i is written only when `byte_wr_en_n`=0 and `lane_sel_n[i]`=0. Lane 0 is bits 7:0, lane 1 bits 15:8, lane 2 bits 23:16 and lane 3 bits 31:24. A write request is `all_wr_n`=0, or `byte_wr_en_n`=0 with at least one lane selected.
- R8: While selected and with no strobe, each cycle is a burst continuation. `advance_n`=0 steps the burst counter before the access; `advance_n`=1 repeats the current address. The cycle writes if a write request is present, and reads otherwise.
- R9: With `burst_interleave`=0, the low two address bits are (first + step) mod 4, and the upper bits keep the value sampled at the start.
- R10: With `burst_interleave`=1, the low two address bits are first XOR step.
- R11: While `sleep`=1, no word is written, the burst state and selection are held, and `dq_drive` is 0. After `sleep` falls, the burst continues from the held state.
- R12: While deselected, `dq_drive` stays 0 whatever `out_en_n` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| cs_a_n | input | 1 | Chip select, active low; also gates the processor strobe |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| proc_strobe_n | input | 1 | Processor address strobe, active low, takes priority |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Global write, active low |
| byte_wr_en_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | LANES | Per-lane byte-write selects, active low |
| burst_interleave | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| addr | input | ADDR_W | Word address |
| dq_in | input | LANES*LANE_W | Write data from the bus |
| dq_out | output | LANES*LANE_W | Read data toward the bus |
| dq_drive | output | 1 | High when the pads should drive `dq_out` |

## Verification
The hardest situation to reach from the ports is a burst that is interrupted by sleep while write inputs and a strobe are both asserted. The check is that, once sleep falls, the next advance continues from the frozen counter and that the frozen word is unchanged. Directed sequences build this case, along with full wraparound bursts in both orders starting from a non-zero low address. In those sequences linear and interleaved order give different addresses. A long random phase follows, with a fixed seed. It mixes strobes, ignored processor strobes, deselects, partial lane writes, sleep and output-enable changes, and a bench model predicts every bus cycle.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

  typedef enum logic [2:0] {
    OP_IDLE     = 3'd0,
    OP_DESEL    = 3'd1,
    OP_SLEEP    = 3'd2,
    OP_START_RD = 3'd3,
    OP_START_WR = 3'd4,
    OP_CONT_RD  = 3'd5,
    OP_CONT_WR  = 3'd6
  } op_e;

  // Low two address bits for a given burst step.
  function automatic logic [1:0] burst_low(input logic [1:0] first,
                                           input logic [1:0] step,
                                           input logic       interleave);
    if (interleave) return first ^ step;
    return first + step;
  endfunction

  function automatic logic op_is_read(input op_e op);
    return (op == OP_START_RD) || (op == OP_CONT_RD);
  endfunction

  function automatic logic op_is_write(input op_e op);
    return (op == OP_START_WR) || (op == OP_CONT_WR);
  endfunction

  function automatic logic op_is_start(input op_e op);
    return (op == OP_START_RD) || (op == OP_START_WR);
  endfunction

endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import sbsram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             sleep,
  input  logic             active,
  input  logic             cs_a_n,
  input  logic             cs_b,
  input  logic             cs_c_n,
  input  logic             proc_strobe_n,
  input  logic             ctrl_strobe_n,
  input  logic             all_wr_n,
  input  logic             byte_wr_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  output op_e              op,
  output logic [LANES-1:0] lane_we,
  output logic             proc_seen
);

  logic             all_sel;
  logic             wr_req;
  logic [LANES-1:0] lanes;

  assign all_sel   = !cs_a_n && cs_b && !cs_c_n;
  // The processor strobe only counts while the first select is active.
  assign proc_seen = !proc_strobe_n && !cs_a_n;
  assign wr_req    = !all_wr_n || (!byte_wr_en_n && (lane_sel_n != '1));
  assign lanes     = !all_wr_n ? '1 : (byte_wr_en_n ? '0 : ~lane_sel_n);

  always_comb begin
    op = OP_IDLE;
    if (sleep)               op = OP_SLEEP;
    else if (proc_seen)      op = all_sel ? OP_START_RD : OP_DESEL;
    else if (!ctrl_strobe_n) op = !all_sel ? OP_DESEL :
                                  (wr_req ? OP_START_WR : OP_START_RD);
    else if (active)         op = wr_req ? OP_CONT_WR : OP_CONT_RD;
  end

  assign lane_we = op_is_write(op) ? lanes : '0;

endmodule

// File: rtl/burst_ctr.sv
module burst_ctr
  import sbsram_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          load,
  input  logic          adv,
  input  logic          interleave,
  input  logic [AW-1:0] load_addr,
  output logic [AW-1:0] use_addr
);

  logic [AW-1:0] base_q, base_d;
  logic [1:0]    step_q, step_d;
  logic [AW-1:0] last_use;

  assign base_d   = load ? load_addr : base_q;
  assign step_d   = load ? 2'd0 : (adv ? step_q + 2'd1 : step_q);
  assign use_addr = {base_d[AW-1:2], burst_low(base_d[1:0], step_d, interleave)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      step_q   <= '0;
      last_use <= '0;
    end else if (en) begin
      base_q   <= base_d;
      step_q   <= step_d;
      last_use <= use_addr;
    end
  end

  // R8: a continuation without advance repeats the previous address
  a_r8_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && !adv && !interleave) |-> (use_addr == last_use));

  // R9: the upper bits stay fixed through a burst
  a_r9_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load) |-> (use_addr[AW-1:2] == last_use[AW-1:2]));

endmodule

// File: rtl/mem_core.sv
module mem_core #(
  parameter int AW     = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic                    re,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we[g]) store[addr] <= wdata[g*LANE_W +: LANE_W];
      if (re)    rd_q        <= store[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_a_n,
  input  logic                    cs_b,
  input  logic                    cs_c_n,
  input  logic                    proc_strobe_n,
  input  logic                    ctrl_strobe_n,
  input  logic                    advance_n,
  input  logic                    all_wr_n,
  input  logic                    byte_wr_en_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic                    burst_interleave,
  input  logic                    out_en_n,
  input  logic                    sleep,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_drive
);

  localparam int DATA_W = LANES * LANE_W;

  op_e               op;
  logic [LANES-1:0]  lane_we;
  logic              proc_seen;
  logic              active;
  logic              rd_valid;
  logic              rd_event;
  logic              wr_event;
  logic              start_event;
  logic              adv_event;
  logic              burst_en;
  logic [ADDR_W-1:0] core_addr;
  logic [DATA_W-1:0] core_rdata;

  cmd_decode #(.LANES(LANES)) u_dec (
    .sleep         (sleep),
    .active        (active),
    .cs_a_n        (cs_a_n),
    .cs_b          (cs_b),
    .cs_c_n        (cs_c_n),
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .all_wr_n      (all_wr_n),
    .byte_wr_en_n  (byte_wr_en_n),
    .lane_sel_n    (lane_sel_n),
    .op            (op),
    .lane_we       (lane_we),
    .proc_seen     (proc_seen)
  );

  assign rd_event    = op_is_read(op);
  assign wr_event    = op_is_write(op);
  assign start_event = op_is_start(op);
  assign burst_en    = rd_event || wr_event;
  assign adv_event   = burst_en && !start_event && !advance_n;

  burst_ctr #(.AW(ADDR_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (burst_en),
    .load       (start_event),
    .adv        (adv_event),
    .interleave (burst_interleave),
    .load_addr  (addr),
    .use_addr   (core_addr)
  );

  mem_core #(.AW(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk   (clk),
    .we    (lane_we),
    .re    (rd_event),
    .addr  (core_addr),
    .wdata (dq_in),
    .rdata (core_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      if (op == OP_DESEL)  active <= 1'b0;
      else if (start_event) active <= 1'b1;
      rd_valid <= rd_event;
    end
  end

  assign dq_out   = core_rdata;
  assign dq_drive = rd_valid && !out_en_n && !sleep;

  // R2: the bus is driven only for a word read at the previous edge
  a_r2_drive_source: assert property (@(posedge clk) disable iff (!rst_n)
    dq_drive |-> $past(rd_event));

  // R4: a processor-strobe start never writes
  a_r4_proc_first_read: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_seen && !sleep) |-> (lane_we == '0));

  // R6: global write touches every lane
  a_r6_global_all: assert property (@(posedge clk) disable iff (!rst_n)
    (!all_wr_n && wr_event) |-> (&lane_we));

  // R11: sleep blocks writes and the bus
  a_r11_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> ((lane_we == '0) && !dq_drive));

  // R12: after a deselect the bus stays released
  a_r12_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DESEL) |=> !dq_drive);

endmodule

// File: tb/burst_sram_test.sv
`timescale 1ns/1ps
module burst_sram_test;

  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_a_n, cs_b, cs_c_n, proc_n, ctrl_n, adv_n, gw_n, bwe_n;
  logic [3:0]  lane_n;
  logic        mode, oe_n, sleep;
  logic [AW-1:0] addr;
  logic [31:0] din;
  logic [31:0] dq_out;
  logic        dq_drive;

  always #5 clk = ~clk;

  burst_sram #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
    .proc_strobe_n(proc_n), .ctrl_strobe_n(ctrl_n), .advance_n(adv_n),
    .all_wr_n(gw_n), .byte_wr_en_n(bwe_n), .lane_sel_n(lane_n),
    .burst_interleave(mode), .out_en_n(oe_n), .sleep(sleep), .addr(addr),
    .dq_in(din), .dq_out(dq_out), .dq_drive(dq_drive)
  );

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_mem [DEPTH];
  logic        m_active;
  int          m_base, m_step;
  logic        exp_rv;
  logic [31:0] exp_data;

  function automatic int order_low(int first, int step, logic il);
    if (il) return first ^ step;
    return (first + step) % 4;
  endfunction

  task automatic model_edge();
    logic sel_all, pseen, wreq, rd, wr;
    logic [3:0] lanes;
    int a;
    if (sleep) begin exp_rv = 1'b0; return; end
    sel_all = !cs_a_n && cs_b && !cs_c_n;
    pseen   = !proc_n && !cs_a_n;
    wreq    = !gw_n || (!bwe_n && lane_n != 4'hF);
    rd = 1'b0; wr = 1'b0;
    if (pseen || !ctrl_n) begin
      if (!sel_all) m_active = 1'b0;
      else begin
        m_active = 1'b1; m_base = int'(addr); m_step = 0;
        if (!pseen && wreq) wr = 1'b1; else rd = 1'b1;
      end
    end else if (m_active) begin
      if (!adv_n) m_step = (m_step + 1) % 4;
      if (wreq) wr = 1'b1; else rd = 1'b1;
    end
    a = (m_base & ~3) | order_low(m_base & 3, m_step, mode);
    lanes = !gw_n ? 4'hF : (bwe_n ? 4'h0 : ~lane_n);
    if (wr) for (int i = 0; i < 4; i++)
      if (lanes[i]) m_mem[a][8*i +: 8] = din[8*i +: 8];
    exp_rv = rd;
    if (rd) exp_data = m_mem[a];
  endtask

  task automatic compare(string tag);
    logic exp_drv;
    exp_drv = exp_rv && !oe_n && !sleep;
    checks++;
    if (dq_drive !== exp_drv) begin
      fails++;
      $display("FAIL %s: dq_drive=%0b expected %0b", tag, dq_drive, exp_drv);
    end
    if (exp_drv) begin
      checks++;
      if (dq_out !== exp_data) begin
        fails++;
        $display("FAIL %s: dq_out=%h expected %h", tag, dq_out, exp_data);
      end
    end
  endtask

  task automatic tick(string tag);
    model_edge();
    @(posedge clk);
    #2;
    compare(tag);
  endtask

  task automatic idle();
    cs_a_n = 1'b0; cs_b = 1'b1; cs_c_n = 1'b0;
    proc_n = 1'b1; ctrl_n = 1'b1; adv_n = 1'b1;
    gw_n = 1'b1; bwe_n = 1'b1; lane_n = 4'hF;
    oe_n = 1'b0; sleep = 1'b0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run still going, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int r;
    r = $urandom(32'h5EED_1234);
    idle();
    rst_n = 1'b0; mode = 1'b0; addr = '0; din = '0;
    m_active = 1'b0; exp_rv = 1'b0; m_base = 0; m_step = 0; exp_data = '0;
    repeat (3) @(posedge clk);
    #2;
    compare("R1");               // reset state with output enable low
    rst_n = 1'b1;
    tick("R1");                  // idle and deselected after reset

    // preload every word with a controller-strobe global write
    for (int a = 0; a < DEPTH; a++) begin
      idle(); ctrl_n = 1'b0; gw_n = 1'b0; addr = AW'(a);
      din = a * 32'h9E37_79B1 ^ 32'h5A5A_0000;
      tick("R5");
    end

    // R2 simple read, then continuation read
    idle(); ctrl_n = 1'b0; addr = 10'd5; tick("R2");
    idle(); tick("R8");
    // R3 output enable without an edge
    oe_n = 1'b1; #1; compare("R3");
    oe_n = 1'b0; #1; compare("R3");

    // R4 processor start with write inputs: read only
    idle(); proc_n = 1'b0; addr = 10'd7; gw_n = 1'b0; din = 32'hAAAA_5555; tick("R4");
    idle(); tick("R4");
    idle(); proc_n = 1'b0; cs_a_n = 1'b1; addr = 10'd9; tick("R4");

    // R5 / R12 deselect paths
    idle(); ctrl_n = 1'b0; cs_b = 1'b0; addr = 10'd3; tick("R5");
    idle(); tick("R12");
    idle(); ctrl_n = 1'b0; addr = 10'd3; tick("R2");
    idle(); proc_n = 1'b0; cs_c_n = 1'b1; tick("R12");
    idle(); tick("R12");

    // R6 global write overrides byte selects
    idle(); ctrl_n = 1'b0; addr = 10'd12; gw_n = 1'b0; din = 32'h1122_3344; tick("R6");
    idle(); ctrl_n = 1'b0; addr = 10'd12; tick("R6");
    // R7 byte lanes
    idle(); ctrl_n = 1'b0; addr = 10'd12; bwe_n = 1'b0; lane_n = 4'b1101;
    din = 32'hFFFF_FFFF; tick("R7");
    idle(); ctrl_n = 1'b0; addr = 10'd12; tick("R7");
    idle(); ctrl_n = 1'b0; addr = 10'd12; lane_n = 4'h0; din = 32'h0; tick("R7");
    idle(); ctrl_n = 1'b0; addr = 10'd12; bwe_n = 1'b0; lane_n = 4'b0111;
    din = 32'h0; tick("R7");
    idle(); ctrl_n = 1'b0; addr = 10'd12; tick("R7");

    // R9 linear burst from low bits 1
    mode = 1'b0;
    idle(); ctrl_n = 1'b0; addr = 10'h021; tick("R9");
    repeat (4) begin idle(); adv_n = 1'b0; tick("R9"); end
    idle(); tick("R8");
    // R10 interleaved burst from low bits 1
    mode = 1'b1;
    idle(); ctrl_n = 1'b0; addr = 10'h021; tick("R10");
    repeat (4) begin idle(); adv_n = 1'b0; tick("R10"); end
    mode = 1'b0;

    // R8 continuation write
    idle(); ctrl_n = 1'b0; addr = 10'h040; tick("R8");
    idle(); adv_n = 1'b0; gw_n = 1'b0; din = 32'hCAFE_0001; tick("R8");
    idle(); ctrl_n = 1'b0; addr = 10'h041; tick("R8");

    // R11 sleep inside a burst
    idle(); ctrl_n = 1'b0; addr = 10'h021; tick("R11");
    idle(); sleep = 1'b1; gw_n = 1'b0; proc_n = 1'b0; addr = 10'h0;
    din = 32'hDEAD_BEEF; tick("R11");
    idle(); sleep = 1'b1; tick("R11");
    idle(); adv_n = 1'b0; tick("R11");
    idle(); ctrl_n = 1'b0; addr = 10'h021; tick("R11");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      idle();
      r = int'($urandom % 100);
      if (r < 15) proc_n = 1'b0;
      else if (r < 30) ctrl_n = 1'b0;
      cs_a_n = ($urandom % 20) == 0;
      cs_b   = ($urandom % 20) != 0;
      cs_c_n = ($urandom % 20) == 0;
      adv_n  = 1'($urandom);
      gw_n   = ($urandom % 7) != 0;
      bwe_n  = 1'($urandom);
      lane_n = 4'($urandom);
      oe_n   = ($urandom % 8) == 0;
      sleep  = ($urandom % 25) == 0;
      addr   = AW'($urandom);
      din    = $urandom;
      if (n % 500 == 0) mode = ~mode;
      tick("R8");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule